// File: doc/BRIEF.md
# One-Time-Programmable ROM Device Model with Mode Decoder

This block is a synthesizable, clocked model of the device side of a byte-wide one-time-programmable read-only memory. It is meant as a verification peer for host-side controllers. The host drives an address, a chip select, an output gate and a program strobe. It also drives two digital flags. One flag stands for a raised programming supply. The other stands for a high voltage on address line 9. From these inputs the block decodes one operating mode and drives or floats its data bus.

The array reads as all ones after reset or after an erase. A program pulse can only clear bits, so each write stores the AND of the old byte and the new byte. When the high-voltage flag is set and the supply is normal, the block stops reading the array. It returns a two-byte identifier instead, chosen by address bit 0. In that mode the other address lines must be zero. If they are not, the block raises an error flag and drives zero.

The storage depth is a parameter, `DEPTH_AW`, which gives the number of address bits that index the array. The default is a reduced 256-byte array. Setting it to 13 models the full 8K-byte part.

Top module: `eprom_device`

## Requirements
- R1: Normal read. With `ce_n`=0, `oe_n`=0, `pgm_n`=1, `vpp_hi`=0 and `a9_hv`=0, the block sets `dq_oe`=1. `dq_out` then shows the stored byte at the current address in the same cycle.
- R2: Output disable. With `ce_n`=0 and `oe_n`=1, the block sets `dq_oe`=0 and `dq_out`=00h.
- R3: Standby and program inhibit. With `ce_n`=1, the block sets `dq_oe`=0 and `dq_out`=00h whatever the other inputs are. No program strobe can change the array while `ce_n`=1.
- R4: Program pulse. Program mode is `ce_n`=0, `oe_n`=1, `pgm_n`=0 and `vpp_hi`=1. While the block is in program mode, `dq_oe`=0 and `dq_in` is sampled on every clock edge. The write happens on the first clock edge at which `pgm_n` is back at 1 after a program-mode cycle. It uses the address and data from the last program-mode edge.
- R5: Clear-only writes. A write stores the bitwise AND of the old byte and `dq_in`. A 1 in the written data never sets a stored 0 back to 1.
- R6: Verify. With `ce_n`=0, `oe_n`=0, `pgm_n`=1 and `vpp_hi`=1, the block drives the stored byte with `dq_oe`=1.
- R7: Identifier readout. With `a9_hv`=1, `ce_n`=0, `oe_n`=0, `pgm_n`=1 and `vpp_hi`=0, every address bit other than bit 0 and bit 9 must be zero. In that case the block drives 9Bh when bit 0 is 0 and 08h when bit 0 is 1, with `dq_oe`=1.
- R8: Identifier misuse. In the R7 mode, if any address bit other than bit 0 or bit 9 is 1, the block sets `proto_err`=1 and `dq_oe`=1 and drives 00h. `proto_err` is 0 in every other case.
- R9: Erase. A one-cycle pulse on `erase` sets every location to FFh, starting from the next cycle.
- R10: Reset. After the synchronous reset `rst`, every location reads FFh.
- R11: Abandoned pulse. If `pgm_n` rises while `ce_n`=1 or `vpp_hi`=0, no write takes place.
- R12: Storage index. Only the low `DEPTH_AW` address bits select a location. Addresses that differ only above that width reach the same byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; fills the array with ones |
| addr | input | 13 | Byte address |
| dq_in | input | 8 | Data to program |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output gate, active low |
| pgm_n | input | 1 | Program strobe, active low |
| vpp_hi | input | 1 | Programming supply raised |
| a9_hv | input | 1 | High voltage present on address line 9 |
| erase | input | 1 | Synchronous erase of the whole array to ones |
| dq_out | output | 8 | Data driven onto the bus (00h when not driving) |
| dq_oe | output | 1 | Data bus drive enable |
| proto_err | output | 1 | Identifier mode entered with a nonzero address |

## Verification
Suppose the program sequencer is left armed when it should be clear, or is cleared when it should stay armed. The result shows at the next read or verify as a byte that differs from the expected AND of all writes to that location. It appears one cycle after the strobe rises. A wrong storage word shows at the next read of that address, and a wrong index width shows as a byte that does or does not alias. A fault in the mode decode shows in the same cycle on `dq_oe`, `dq_out` or `proto_err`, because the output path has no register. The bench therefore reads back every location it touched right after each write, erase or abandoned pulse.

// File: rtl/eprom_pkg.sv
package eprom_pkg;

    localparam int unsigned ADDR_W     = 13;
    localparam int unsigned DATA_W     = 8;
    localparam int unsigned SIG_HV_BIT = 9;

    localparam logic [DATA_W-1:0] SIG_MAKER  = 8'h9B;
    localparam logic [DATA_W-1:0] SIG_DEVICE = 8'h08;
    localparam logic [DATA_W-1:0] BLANK_BYTE = '1;

    typedef enum logic [2:0] {
        M_STANDBY,
        M_INHIBIT,
        M_DISABLE,
        M_READ,
        M_VERIFY,
        M_PROGRAM,
        M_SIGNATURE,
        M_ILLEGAL
    } mode_e;

    typedef struct packed {
        logic              drive;
        logic              err;
        logic [DATA_W-1:0] data;
    } bus_out_t;

    // Priority: chip select, then output gate, then strobe, then supply, then A9 flag.
    function automatic mode_e decode_mode(
        input logic ce_n,
        input logic oe_n,
        input logic pgm_n,
        input logic vpp_hi,
        input logic a9_hv
    );
        mode_e m;
        if (ce_n)
            m = vpp_hi ? M_INHIBIT : M_STANDBY;
        else if (oe_n)
            m = (!pgm_n && vpp_hi) ? M_PROGRAM : M_DISABLE;
        else if (!pgm_n)
            m = M_ILLEGAL;
        else if (vpp_hi)
            m = M_VERIFY;
        else if (a9_hv)
            m = M_SIGNATURE;
        else
            m = M_READ;
        return m;
    endfunction

    // True when every address bit other than bit 0 and the high-voltage line is zero.
    function automatic logic sig_addr_clean(input logic [ADDR_W-1:0] a);
        logic [ADDR_W-1:0] mask;
        mask             = '1;
        mask[0]          = 1'b0;
        mask[SIG_HV_BIT] = 1'b0;
        return (a & mask) == '0;
    endfunction

endpackage

// File: rtl/eprom_mode_dec.sv
module eprom_mode_dec
    import eprom_pkg::*;
(
    input  logic  ce_n,
    input  logic  oe_n,
    input  logic  pgm_n,
    input  logic  vpp_hi,
    input  logic  a9_hv,
    output mode_e mode
);

    always_comb begin
        mode = decode_mode(ce_n, oe_n, pgm_n, vpp_hi, a9_hv);
    end

endmodule

// File: rtl/eprom_prog_ctl.sv
module eprom_prog_ctl
    import eprom_pkg::*;
#(
    parameter int unsigned IDX_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  mode_e             mode,
    input  logic              ce_n,
    input  logic              pgm_n,
    input  logic              vpp_hi,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] din,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [DATA_W-1:0] wr_data
);

    logic              armed_q;
    logic [IDX_W-1:0]  cap_idx_q;
    logic [DATA_W-1:0] cap_data_q;

    // Armed only while the previous edge saw program mode; any other mode drops it.
    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q    <= 1'b0;
            cap_idx_q  <= '0;
            cap_data_q <= '0;
        end else begin
            armed_q <= (mode == M_PROGRAM);
            if (mode == M_PROGRAM) begin
                cap_idx_q  <= idx;
                cap_data_q <= din;
            end
        end
    end

    // Strobe has returned high with the chip still selected and supply still raised.
    always_comb begin
        wr_en   = armed_q && pgm_n && !ce_n && vpp_hi;
        wr_idx  = cap_idx_q;
        wr_data = cap_data_q;
    end

endmodule

// File: rtl/eprom_cell_array.sv
module eprom_cell_array
    import eprom_pkg::*;
#(
    parameter int unsigned IDX_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              erase,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    localparam int unsigned DEPTH  = 1 << IDX_W;
    localparam int unsigned FLAT_W = DEPTH * DATA_W;

    logic [FLAT_W-1:0] flat;

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        logic [DATA_W-1:0] word_q;
        logic              hit;

        assign hit = wr_en && (wr_idx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (rst || erase)
                word_q <= BLANK_BYTE;
            else if (hit)
                word_q <= word_q & wr_data;
        end

        assign flat[g*DATA_W +: DATA_W] = word_q;
    end

    always_comb begin
        rd_data = flat[rd_idx*DATA_W +: DATA_W];
    end

endmodule

// File: rtl/eprom_out_mux.sv
module eprom_out_mux
    import eprom_pkg::*;
(
    input  mode_e             mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] rd_data,
    output bus_out_t          bus
);

    always_comb begin
        bus = '0;
        unique case (mode)
            M_READ, M_VERIFY: begin
                bus.drive = 1'b1;
                bus.data  = rd_data;
            end
            M_SIGNATURE: begin
                bus.drive = 1'b1;
                if (sig_addr_clean(addr))
                    bus.data = addr[0] ? SIG_DEVICE : SIG_MAKER;
                else
                    bus.err = 1'b1;
            end
            default: bus = '0;
        endcase
    end

endmodule

// File: rtl/eprom_device.sv
module eprom_device
    import eprom_pkg::*;
#(
    parameter int unsigned DEPTH_AW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              pgm_n,
    input  logic              vpp_hi,
    input  logic              a9_hv,
    input  logic              erase,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    output logic              proto_err
);

    localparam int unsigned IDX_W = (DEPTH_AW > ADDR_W) ? ADDR_W : DEPTH_AW;

    mode_e             mode;
    logic [IDX_W-1:0]  idx;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] rd_data;
    bus_out_t          bus;

    assign idx = addr[IDX_W-1:0];

    eprom_mode_dec u_dec (
        .ce_n   (ce_n),
        .oe_n   (oe_n),
        .pgm_n  (pgm_n),
        .vpp_hi (vpp_hi),
        .a9_hv  (a9_hv),
        .mode   (mode)
    );

    eprom_prog_ctl #(.IDX_W(IDX_W)) u_prog (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode),
        .ce_n    (ce_n),
        .pgm_n   (pgm_n),
        .vpp_hi  (vpp_hi),
        .idx     (idx),
        .din     (dq_in),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data)
    );

    eprom_cell_array #(.IDX_W(IDX_W)) u_array (
        .clk     (clk),
        .rst     (rst),
        .erase   (erase),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (idx),
        .rd_data (rd_data)
    );

    eprom_out_mux u_mux (
        .mode    (mode),
        .addr    (addr),
        .rd_data (rd_data),
        .bus     (bus)
    );

    assign dq_out    = bus.data;
    assign dq_oe     = bus.drive;
    assign proto_err = bus.err;

endmodule

// File: rtl/eprom_device_chk.sv
module eprom_device_chk
    import eprom_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic              ce_n,
    input logic              oe_n,
    input logic              pgm_n,
    input logic              vpp_hi,
    input logic              a9_hv,
    input logic              erase,
    input logic [DATA_W-1:0] dq_out,
    input logic              dq_oe,
    input logic              proto_err
);

    logic rd_plain;
    logic sig_sel;
    assign rd_plain = !ce_n && !oe_n && pgm_n && !vpp_hi && !a9_hv;
    assign sig_sel  = !ce_n && !oe_n && pgm_n && !vpp_hi && a9_hv;

    // R3: deselected chip never drives
    p_standby_float_r3: assert property (@(posedge clk) disable iff (rst)
        ce_n |-> (!dq_oe && dq_out == '0));

    // R2: output gate high floats the bus
    p_gate_off_r2: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && oe_n) |-> (!dq_oe && dq_out == '0));

    // R7: clean identifier access returns the fixed bytes
    p_sig_bytes_r7: assert property (@(posedge clk) disable iff (rst)
        (sig_sel && !proto_err) |-> (dq_oe && dq_out == (addr[0] ? SIG_DEVICE : SIG_MAKER)));

    // R8: error flag only in identifier mode, with zero data driven
    p_err_scope_r8: assert property (@(posedge clk) disable iff (rst)
        proto_err |-> (sig_sel && dq_oe && dq_out == '0));

    // R5: between back-to-back plain reads of one address no stored bit rises
    p_clear_only_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_plain && $past(rd_plain) && $stable(addr) && !$past(erase) && !$past(rst))
            |-> ((dq_out & ~$past(dq_out)) == '0));

    // R9: a read right after erase sees a blank byte
    p_erase_blank_r9: assert property (@(posedge clk) disable iff (rst)
        (rd_plain && $past(erase)) |-> (dq_out == BLANK_BYTE));

endmodule

bind eprom_device eprom_device_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .addr      (addr),
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .pgm_n     (pgm_n),
    .vpp_hi    (vpp_hi),
    .a9_hv     (a9_hv),
    .erase     (erase),
    .dq_out    (dq_out),
    .dq_oe     (dq_oe),
    .proto_err (proto_err)
);

// File: tb/eprom_device_bench.sv
module eprom_device_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [12:0] addr = '0;
    logic [7:0]  dq_in = '0;
    logic        ce_n = 1'b1, oe_n = 1'b1, pgm_n = 1'b1;
    logic        vpp_hi = 1'b0, a9_hv = 1'b0, erase = 1'b0;
    logic [7:0]  dq_out;
    logic        dq_oe, proto_err;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    eprom_device u_eprom_device (
        .clk(clk), .rst(rst), .addr(addr), .dq_in(dq_in),
        .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n), .vpp_hi(vpp_hi),
        .a9_hv(a9_hv), .erase(erase),
        .dq_out(dq_out), .dq_oe(dq_oe), .proto_err(proto_err)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic idle();
        ce_n = 1; oe_n = 1; pgm_n = 1; vpp_hi = 0; a9_hv = 0; erase = 0;
    endtask

    // plain read: expect drive, data, no error
    task automatic rd_expect(input string req, input logic [12:0] a, input logic [7:0] e);
        idle(); addr = a; ce_n = 0; oe_n = 0;
        #2;
        chk(req, {6'd0, proto_err, dq_oe, dq_out}, {6'd0, 1'b0, 1'b1, e});
        tick();
    endtask

    // full pulse: one program-mode edge, then strobe rises
    task automatic prog(input logic [12:0] a, input logic [7:0] d);
        idle(); addr = a; dq_in = d; ce_n = 0; vpp_hi = 1; pgm_n = 0;
        tick();
        pgm_n = 1;
        tick();
        idle();
    endtask

    task automatic t_reset();
        rd_expect("R10 reset blank lo", 13'h0000, 8'hFF);
        rd_expect("R10 reset blank hi", 13'h00FF, 8'hFF);
    endtask

    task automatic t_read_disable();
        prog(13'h0010, 8'hA5);
        rd_expect("R1 read back", 13'h0010, 8'hA5);
        idle(); addr = 13'h0010; ce_n = 0; oe_n = 1; #2;
        chk("R2 gate off", {7'd0, dq_oe, dq_out}, 16'h0000);
        tick();
    endtask

    task automatic t_program_verify();
        // last sampled low-cycle data wins
        idle(); addr = 13'h0021; dq_in = 8'h00; ce_n = 0; vpp_hi = 1; pgm_n = 0; #2;
        chk("R4 bus floats while programming", {15'd0, dq_oe}, 16'h0000);
        tick();
        dq_in = 8'h5A; tick();
        pgm_n = 1; tick(); idle();
        rd_expect("R4 last sample stored", 13'h0021, 8'h5A);
        // verify mode with supply still high
        idle(); addr = 13'h0021; ce_n = 0; oe_n = 0; vpp_hi = 1; #2;
        chk("R6 verify drive", {7'd0, dq_oe, dq_out}, {7'd0, 1'b1, 8'h5A});
        tick();
    endtask

    task automatic t_clear_only();
        prog(13'h0030, 8'hF0);
        prog(13'h0030, 8'h3C);
        rd_expect("R5 and of writes", 13'h0030, 8'h30);
        prog(13'h0030, 8'hFF);
        rd_expect("R5 ones do not set", 13'h0030, 8'h30);
    endtask

    task automatic t_standby();
        idle(); addr = 13'h0010; ce_n = 1; oe_n = 0; #2;
        chk("R3 standby floats", {7'd0, dq_oe, dq_out}, 16'h0000);
        tick();
        idle(); addr = 13'h0040; dq_in = 8'h00; ce_n = 1; vpp_hi = 1; pgm_n = 0; #2;
        chk("R3 inhibit floats", {7'd0, dq_oe, dq_out}, 16'h0000);
        tick();
        pgm_n = 1; tick(); idle();
        rd_expect("R3 inhibit no write", 13'h0040, 8'hFF);
    endtask

    task automatic t_abandon();
        idle(); addr = 13'h0041; dq_in = 8'h00; ce_n = 0; vpp_hi = 1; pgm_n = 0; tick();
        ce_n = 1; pgm_n = 1; tick();
        ce_n = 0; tick(); idle();
        rd_expect("R11 select dropped", 13'h0041, 8'hFF);
        idle(); addr = 13'h0042; dq_in = 8'h00; ce_n = 0; vpp_hi = 1; pgm_n = 0; tick();
        vpp_hi = 0; pgm_n = 1; tick(); idle();
        rd_expect("R11 supply dropped", 13'h0042, 8'hFF);
    endtask

    task automatic sig_expect(input string req, input logic [12:0] a, input logic err,
                              input logic [7:0] e);
        idle(); addr = a; ce_n = 0; oe_n = 0; a9_hv = 1; #2;
        chk(req, {6'd0, proto_err, dq_oe, dq_out}, {6'd0, err, 1'b1, e});
        tick();
    endtask

    task automatic t_signature();
        sig_expect("R7 maker byte", 13'h0000, 1'b0, 8'h9B);
        sig_expect("R7 device byte", 13'h0001, 1'b0, 8'h08);
        sig_expect("R7 bit9 exempt", 13'h0201, 1'b0, 8'h08);
    endtask

    task automatic t_proto();
        sig_expect("R8 low bit set", 13'h0004, 1'b1, 8'h00);
        sig_expect("R8 high bit set", 13'h1001, 1'b1, 8'h00);
        // leaving the mode clears the flag
        rd_expect("R8 flag clear in read", 13'h0000, 8'hFF);
    endtask

    task automatic t_alias();
        prog(13'h0105, 8'h77);
        rd_expect("R12 alias low", 13'h0005, 8'h77);
        rd_expect("R12 alias high", 13'h1F05, 8'h77);
    endtask

    task automatic t_erase();
        idle(); erase = 1; tick(); erase = 0;
        rd_expect("R9 erased a", 13'h0010, 8'hFF);
        rd_expect("R9 erased b", 13'h0030, 8'hFF);
        rd_expect("R9 erased c", 13'h0005, 8'hFF);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        idle();
        rst = 1;
        repeat (3) tick();
        rst = 0;
        tick();
        t_reset();
        t_read_disable();
        t_program_verify();
        t_clear_only();
        t_standby();
        t_abandon();
        t_signature();
        t_proto();
        t_alias();
        t_erase();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end

endmodule